// File: doc/BRIEF.md
# Low-Power Mode Controller

This block sequences the sleep states of a small microcontroller core. The instruction decoder raises a one-cycle request to enter one of two sleep depths. The shallow depth is called WAIT. The deep depth is called STOP. For each state the block drives the clock-enable outputs:

- the oscillator enable;
- the frequency-multiplier (PLL) enable;
- the system clock enable;
- the combined CPU / bus-interface clock enable;
- the enable for the peripheral divided clocks;
- the enable for the watchdog clocks.

While the core sleeps, the block also fixes the external bus control pins at safe levels. It latches the address bus at its last value.

An interrupt request or a hardware reset ends either sleep state. After a wake from STOP, software can choose to resume at once. Otherwise the CPU clock stays held off while a settling counter lets the oscillator stabilise.

All inputs and outputs are plain level signals. No interface carries a data stream, so the block has no handshake and no back-pressure.

Top module: `lpm_ctrl`

## Requirements
- R1: While `rst_n` is low and after it is released, `mode` is 0 (RUN). All six enables are 1 and `wake_done` is 0. The `mode` encoding is 0 RUN, 1 STOP, 2 WAIT, 3 SETTLE.
- R2: In RUN, a `stop_req` pulse moves the block to STOP at the next clock edge. In STOP all six enables are 0. If `stop_req` and `wait_req` are both high, `stop_req` wins.
- R3: In RUN, a `wait_req` pulse moves the block to WAIT at the next clock edge. In WAIT:
  - `osc_en` is 1 and `cpu_clk_en` is 0;
  - `pll_en` follows `pll_keep`;
  - `sys_clk_en`, `periph_clk_en` and `wdt_clk_en` each equal the inverse of `wait_sys_off`.
- R4: In WAIT, `irq_req` returns the block to RUN at the next edge.
- R5: In STOP with `stop_settle_en` = 0, `irq_req` returns the block to RUN at the next edge.
- R6: In STOP with `stop_settle_en` = 1, `irq_req` moves the block to SETTLE.
  - The block stays in SETTLE for exactly SETTLE_CYC cycles and then enters RUN.
  - During SETTLE only `cpu_clk_en` is 0; the other five enables are 1.
- R7: `stop_req` and `wait_req` are ignored outside RUN. `irq_req` is ignored in RUN and in SETTLE.
- R8: Driving `rst_n` low forces RUN at once from any state. It also clears the settling counter, so the next SETTLE again lasts the full SETTLE_CYC cycles.
- R9: `bus_hold` is 1 whenever `mode` is not RUN. While `bus_hold` is 1:
  - `addr_out` keeps the `addr_in` value sampled at the edge that left RUN;
  - `data_oe_out` is 0, `rd_n_out` and `wr_n_out` are 1, and `ale_out` is 0.

  In RUN the four bus signals pass through unchanged.
- R10: `wake_done` is a one-cycle pulse in the first RUN cycle after STOP, WAIT or SETTLE. It stays 0 at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running controller clock |
| rst_n | input | 1 | Hardware reset, active low, asynchronous |
| stop_req | input | 1 | One-cycle request to enter STOP |
| wait_req | input | 1 | One-cycle request to enter WAIT |
| irq_req | input | 1 | Any pending interrupt request |
| wait_sys_off | input | 1 | 1: gate system and peripheral clocks in WAIT |
| pll_keep | input | 1 | 1: PLL keeps running in WAIT |
| stop_settle_en | input | 1 | 1: count settling time on wake from STOP |
| addr_in | input | ADDR_W | Address from the bus interface |
| data_oe_in | input | 1 | Data-bus drive enable from the bus interface |
| rd_n_in | input | 1 | Read strobe from the bus interface |
| wr_n_in | input | 1 | Write strobe from the bus interface |
| ale_in | input | 1 | Address-latch strobe from the bus interface |
| addr_out | output | ADDR_W | Address to the pins |
| data_oe_out | output | 1 | Data-bus drive enable to the pins |
| rd_n_out | output | 1 | Read strobe to the pins |
| wr_n_out | output | 1 | Write strobe to the pins |
| ale_out | output | 1 | Address-latch strobe to the pins |
| osc_en | output | 1 | Oscillator enable |
| pll_en | output | 1 | PLL multiplier enable |
| sys_clk_en | output | 1 | System clock enable |
| cpu_clk_en | output | 1 | CPU and bus-interface clock enable |
| periph_clk_en | output | 1 | Peripheral divided-clock enable |
| wdt_clk_en | output | 1 | Watchdog clock enable |
| bus_hold | output | 1 | Bus pins are frozen |
| wake_done | output | 1 | One-cycle pulse when the CPU clock restarts |
| mode | output | 2 | Current state (0 RUN, 1 STOP, 2 WAIT, 3 SETTLE) |

## Verification
The bench builds the controller with SETTLE_CYC = 5 and ADDR_W = 8. A settling window of five cycles is short enough to count edge by edge. It still gives room to hit SETTLE with a stray stop request and a stray interrupt inside the window. It also lets reset arrive in the middle of the count, after which a fresh window is checked to last the full five cycles. The narrow address keeps the bus-freeze values easy to tell apart. The freeze is checked as the bus goes into STOP and as it comes out.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_STOP   = 2'd1,
    ST_WAIT   = 2'd2,
    ST_SETTLE = 2'd3
  } lpm_state_e;
endpackage

// File: rtl/lpm_settle_cnt.sv
module lpm_settle_cnt #(
  parameter int SETTLE_CYC = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  output logic done
);
  localparam int CW = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(SETTLE_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (!active)     cnt <= '0;
    else if (cnt != LAST) cnt <= cnt + 1'b1;
  end

  assign done = active && (cnt == LAST);

  // R6
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);

  // R8
  cnt_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (cnt == '0));
endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm
  import lpm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stop_req,
  input  logic       wait_req,
  input  logic       irq_req,
  input  logic       stop_settle_en,
  input  logic       settle_done,
  output lpm_state_e state
);
  lpm_state_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_RUN:    if (stop_req) nxt = ST_STOP;
                 else if (wait_req) nxt = ST_WAIT;
      ST_STOP:   if (irq_req) nxt = stop_settle_en ? ST_SETTLE : ST_RUN;
      ST_WAIT:   if (irq_req) nxt = ST_RUN;
      ST_SETTLE: if (settle_done) nxt = ST_RUN;
      default:   nxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_RUN;
    else        state <= nxt;
  end

  // R2
  stop_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && stop_req) |=> (state == ST_STOP));

  // R7
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT && !irq_req) |=> (state == ST_WAIT));

  // R4
  wait_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT && irq_req) |=> (state == ST_RUN));
endmodule

// File: rtl/lpm_bus_hold.sv
module lpm_bus_hold #(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              data_oe_in,
  input  logic              rd_n_in,
  input  logic              wr_n_in,
  input  logic              ale_in,
  output logic [ADDR_W-1:0] addr_out,
  output logic              data_oe_out,
  output logic              rd_n_out,
  output logic              wr_n_out,
  output logic              ale_out
);
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     addr_q <= '0;
    else if (!hold) addr_q <= addr_in;
  end

  assign addr_out    = hold ? addr_q : addr_in;
  assign data_oe_out = data_oe_in & ~hold;
  assign rd_n_out    = rd_n_in | hold;
  assign wr_n_out    = wr_n_in | hold;
  assign ale_out     = ale_in & ~hold;

  // R9
  bus_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> (rd_n_out && wr_n_out && !data_oe_out && !ale_out));

  // R9
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && $past(hold)) |-> $stable(addr_out));
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
#(
  parameter int SETTLE_CYC = 1024,
  parameter int ADDR_W     = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stop_req,
  input  logic              wait_req,
  input  logic              irq_req,
  input  logic              wait_sys_off,
  input  logic              pll_keep,
  input  logic              stop_settle_en,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              data_oe_in,
  input  logic              rd_n_in,
  input  logic              wr_n_in,
  input  logic              ale_in,
  output logic [ADDR_W-1:0] addr_out,
  output logic              data_oe_out,
  output logic              rd_n_out,
  output logic              wr_n_out,
  output logic              ale_out,
  output logic              osc_en,
  output logic              pll_en,
  output logic              sys_clk_en,
  output logic              cpu_clk_en,
  output logic              periph_clk_en,
  output logic              wdt_clk_en,
  output logic              bus_hold,
  output logic              wake_done,
  output logic [1:0]        mode
);
  lpm_state_e state;
  logic       settle_done;
  logic       cpu_en_q;

  lpm_settle_cnt #(.SETTLE_CYC(SETTLE_CYC)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (state == ST_SETTLE),
    .done   (settle_done)
  );

  lpm_fsm u_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .stop_req       (stop_req),
    .wait_req       (wait_req),
    .irq_req        (irq_req),
    .stop_settle_en (stop_settle_en),
    .settle_done    (settle_done),
    .state          (state)
  );

  always_comb begin
    osc_en        = 1'b1;
    pll_en        = 1'b1;
    sys_clk_en    = 1'b1;
    cpu_clk_en    = 1'b1;
    periph_clk_en = 1'b1;
    wdt_clk_en    = 1'b1;
    unique case (state)
      ST_STOP: begin
        osc_en = 1'b0; pll_en = 1'b0; sys_clk_en = 1'b0;
        cpu_clk_en = 1'b0; periph_clk_en = 1'b0; wdt_clk_en = 1'b0;
      end
      ST_WAIT: begin
        pll_en        = pll_keep;
        sys_clk_en    = ~wait_sys_off;
        periph_clk_en = ~wait_sys_off;
        wdt_clk_en    = ~wait_sys_off;
        cpu_clk_en    = 1'b0;
      end
      ST_SETTLE: cpu_clk_en = 1'b0;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cpu_en_q <= 1'b1;
    else        cpu_en_q <= cpu_clk_en;
  end

  assign wake_done = cpu_clk_en & ~cpu_en_q;
  assign bus_hold  = (state != ST_RUN);
  assign mode      = state;

  lpm_bus_hold #(.ADDR_W(ADDR_W)) u_bus (
    .clk         (clk),
    .rst_n       (rst_n),
    .hold        (bus_hold),
    .addr_in     (addr_in),
    .data_oe_in  (data_oe_in),
    .rd_n_in     (rd_n_in),
    .wr_n_in     (wr_n_in),
    .ale_in      (ale_in),
    .addr_out    (addr_out),
    .data_oe_out (data_oe_out),
    .rd_n_out    (rd_n_out),
    .wr_n_out    (wr_n_out),
    .ale_out     (ale_out)
  );

  // R2
  stop_all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1) |-> !(osc_en | pll_en | sys_clk_en | cpu_clk_en | periph_clk_en | wdt_clk_en));

  // R10
  wake_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_done |=> !wake_done);

  // R6
  settle_cpu_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3) |-> (!cpu_clk_en && osc_en && sys_clk_en));

  // R9
  hold_when_asleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_clk_en |-> bus_hold);
endmodule

// File: tb/lpm_ctrl_test.sv
module lpm_ctrl_test;
  localparam int AW = 8;
  localparam int SC = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stop_req = 0, wait_req = 0, irq_req = 0;
  logic wait_sys_off = 0, pll_keep = 0, stop_settle_en = 0;
  logic [AW-1:0] addr_in = '0;
  logic data_oe_in = 1, rd_n_in = 0, wr_n_in = 0, ale_in = 1;
  logic [AW-1:0] addr_out;
  logic data_oe_out, rd_n_out, wr_n_out, ale_out;
  logic osc_en, pll_en, sys_clk_en, cpu_clk_en, periph_clk_en, wdt_clk_en;
  logic bus_hold, wake_done;
  logic [1:0] mode;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  lpm_ctrl #(.SETTLE_CYC(SC), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .wait_req(wait_req),
    .irq_req(irq_req), .wait_sys_off(wait_sys_off), .pll_keep(pll_keep),
    .stop_settle_en(stop_settle_en), .addr_in(addr_in), .data_oe_in(data_oe_in),
    .rd_n_in(rd_n_in), .wr_n_in(wr_n_in), .ale_in(ale_in), .addr_out(addr_out),
    .data_oe_out(data_oe_out), .rd_n_out(rd_n_out), .wr_n_out(wr_n_out),
    .ale_out(ale_out), .osc_en(osc_en), .pll_en(pll_en), .sys_clk_en(sys_clk_en),
    .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en), .wdt_clk_en(wdt_clk_en),
    .bus_hold(bus_hold), .wake_done(wake_done), .mode(mode)
  );

  function automatic logic [5:0] ens();
    return {osc_en, pll_en, sys_clk_en, cpu_clk_en, periph_clk_en, wdt_clk_en};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // fields: stop,wait,irq,sys_off,pll,settle | mode[1:0] | en{osc,pll,sys,cpu,per,wdt} | wake
  localparam int NV = 16;
  localparam logic [14:0] VEC [NV] = '{
    {6'b000000, 2'd0, 6'b111111, 1'b0}, // R1 idle run
    {6'b010010, 2'd2, 6'b111011, 1'b0}, // R3 wait, sys on, pll kept
    {6'b100100, 2'd2, 6'b100000, 1'b0}, // R7 stop ignored; R3 sys off, pll off
    {6'b001000, 2'd0, 6'b111111, 1'b1}, // R4 wake from wait, R10
    {6'b001000, 2'd0, 6'b111111, 1'b0}, // R7 irq in run ignored, R10
    {6'b110000, 2'd1, 6'b000000, 1'b0}, // R2 stop wins over wait
    {6'b010000, 2'd1, 6'b000000, 1'b0}, // R7 wait ignored in stop
    {6'b001000, 2'd0, 6'b111111, 1'b1}, // R5 immediate wake
    {6'b100000, 2'd1, 6'b000000, 1'b0}, // R2
    {6'b001001, 2'd3, 6'b111011, 1'b0}, // R6 settle cycle 1
    {6'b000001, 2'd3, 6'b111011, 1'b0}, // R6 cycle 2
    {6'b100001, 2'd3, 6'b111011, 1'b0}, // R7 stop ignored in settle
    {6'b001001, 2'd3, 6'b111011, 1'b0}, // R7 irq ignored in settle
    {6'b000001, 2'd3, 6'b111011, 1'b0}, // R6 cycle 5
    {6'b000001, 2'd0, 6'b111111, 1'b1}, // R6 back to run, R10
    {6'b000000, 2'd0, 6'b111111, 1'b0}  // R10 single pulse
  };

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1 mode in reset", 32'(mode), 0);
    chk("R1 enables in reset", 32'(ens()), 6'h3F);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 mode after reset", 32'(mode), 0);
    chk("R1 wake_done after reset", 32'(wake_done), 0);

    for (int i = 0; i < NV; i++) begin
      {stop_req, wait_req, irq_req, wait_sys_off, pll_keep, stop_settle_en} = VEC[i][14:9];
      @(negedge clk);
      stop_req = 0; wait_req = 0; irq_req = 0;
      chk($sformatf("vec %0d mode", i), 32'(mode), 32'(VEC[i][8:7]));
      chk($sformatf("vec %0d enables", i), 32'(ens()), 32'(VEC[i][6:1]));
      chk($sformatf("vec %0d wake_done", i), 32'(wake_done), 32'(VEC[i][0]));
    end

    // R8 reset in the middle of a settling window
    stop_settle_en = 1; wait_sys_off = 0; pll_keep = 1;
    stop_req = 1; @(negedge clk); stop_req = 0;
    irq_req = 1;  @(negedge clk); irq_req = 0;
    @(negedge clk);
    chk("R8 in settle before reset", 32'(mode), 3);
    #1 rst_n = 1'b0;
    #0.5;
    chk("R8 async reset mode", 32'(mode), 0);
    chk("R8 async reset enables", 32'(ens()), 6'h3F);
    @(negedge clk); rst_n = 1'b1;
    stop_req = 1; @(negedge clk); stop_req = 0;
    irq_req = 1;  @(negedge clk); irq_req = 0;
    begin
      int n = 0;
      while (mode == 2'd3 && n < 50) begin n++; @(negedge clk); end
      chk("R8 R6 full settle length after reset", 32'(n), SC);
    end
    chk("R6 wake pulse after settle", 32'(wake_done), 1);

    // R9 bus freeze
    stop_settle_en = 0;
    addr_in = 8'hA5;
    @(negedge clk);
    chk("R9 pass-through addr", 32'(addr_out), 8'hA5);
    chk("R9 pass-through strobes", 32'({data_oe_out, rd_n_out, wr_n_out, ale_out}), 4'b1001);
    addr_in = 8'h3C; stop_req = 1; @(negedge clk); stop_req = 0;
    addr_in = 8'hFF;
    #0.5;
    chk("R9 bus_hold", 32'(bus_hold), 1);
    chk("R9 held addr", 32'(addr_out), 8'h3C);
    chk("R9 forced strobes", 32'({data_oe_out, rd_n_out, wr_n_out, ale_out}), 4'b0110);
    irq_req = 1; @(negedge clk); irq_req = 0;
    chk("R9 release addr", 32'(addr_out), 8'hFF);
    chk("R9 release bus_hold", 32'(bus_hold), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule